// File: doc/BRIEF.md
# External Interrupt Request Flag Controller

This block turns six external, active-low request lines into sticky status flags that software and the exception logic can inspect and clear. Each line first crosses into the clock domain through a two-stage synchronizer. A per-line sense bit then picks one of two detection modes. In level mode, a low synchronized input keeps the flag set. In edge mode, a high-to-low transition of the synchronized input sets the flag.

Software reaches two 8-bit registers over a simple synchronous bus: a status register that holds the flags and an enable register. Software clears a flag by writing 0 to it, but only after it has read that flag as 1. The exception sequencer can also clear a flag with a per-line acknowledge pulse. The block drives a per-line pending output, which is the flag gated by its enable bit. Priority selection and vectoring are left to a downstream block.

Top module: `irq_flag_ctrl`

## Requirements
- R1: After reset, the status register reads 0x00, the enable register reads 0x00 and all six pending outputs are 0.
- R2: Register select 0 addresses the status register and select 1 addresses the enable register. Read data is valid combinationally in the same cycle as the read strobe.
- R3: Status bits 7 and 6 always read 0. Writes to them have no effect.
- R4: Writing 1 to a status flag bit never sets that flag.
- R5: A 0 written to status bit n clears flag n only if a status read returned that flag as 1 since the last status write. Otherwise the flag is left unchanged. Any status write cancels all pending read marks.
- R6: In level mode (sense bit n = 0), flag n is set while the synchronized input is low. The flag reads 1 from the third rising edge after the input is first sampled low.
- R7: In edge mode (sense bit n = 1), flag n is set by a high-to-low transition of the synchronized input. An input that stays low does not set the flag again after it has been cleared.
- R8: In level mode, the acknowledge for line n clears flag n only when the synchronized input is high. In edge mode, the acknowledge clears the flag unconditionally.
- R9: When a set condition and any clear occur for the same flag in the same cycle, the flag stays set.
- R10: All 8 bits of the enable register are readable and writable. A written value reads back unchanged.
- R11: Pending output n equals flag n AND enable bit n. Enable bits 7 and 6 drive no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 6 | Asynchronous active-low request lines |
| sense_edge | input | 6 | Per-line sense select: 0 for low level, 1 for falling edge |
| ack | input | 6 | Per-line acknowledge pulse from the exception sequencer |
| bus_sel | input | 1 | Register select: 0 for status, 1 for enable |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register |
| pending | output | 6 | Flag AND enable, one bit per line |

## Verification
The read marks are invisible at the ports. A stale or missing mark only shows up on the first status write after a read. The flag then either survives a write it should not survive, or clears without a prior read, and the status read that follows exposes it. A synchronizer or edge register with a wrong reset value, or a lost previous-value copy, shows up within three cycles as a spurious flag, or as a flag that sets again while a line is held low. An acknowledge gated in the wrong way is visible on the first status read after the pulse. The bench therefore checks the flag after every write, acknowledge and line transition, not only at the end of each sequence.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;
  localparam int unsigned NUM_LINES = 6;
  localparam int unsigned REG_W     = 8;
  localparam int unsigned SYNC_LEN  = 2;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_ENABLE = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int unsigned WIDTH  = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [WIDTH-1:0] d;
      if (s == 0) begin : g_first
        assign d = async_in;
      end else begin : g_rest
        assign d = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else        stage_q[s] <= d;
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/irq_detect.sv
module irq_detect #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] sync_lvl,
  input  logic [WIDTH-1:0] sense_edge,
  output logic [WIDTH-1:0] set_req,
  output logic [WIDTH-1:0] line_high
);
  logic [WIDTH-1:0] prev_q;
  logic [WIDTH-1:0] prev_d;

  always_comb begin
    prev_d = sync_lvl;
    for (int i = 0; i < WIDTH; i++) begin
      if (sense_edge[i]) set_req[i] = prev_q[i] & ~sync_lvl[i];
      else               set_req[i] = ~sync_lvl[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '1;
    else        prev_q <= prev_d;
  end

  assign line_high = sync_lvl;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_chk
      // Edge mode fires for one cycle only: no second request while the line stays low.
      assert_edge_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sense_edge[i] && $past(sense_edge[i]) && $past(set_req[i]) && !sync_lvl[i])
          |-> !set_req[i]);
    end
  endgenerate
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int unsigned WIDTH = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] set_req,
  input  logic [WIDTH-1:0] line_high,
  input  logic [WIDTH-1:0] sense_edge,
  input  logic [WIDTH-1:0] ack,
  input  logic             sw_rd,
  input  logic             sw_wr,
  input  logic [WIDTH-1:0] sw_wdata,
  output logic [WIDTH-1:0] flags
);
  logic [WIDTH-1:0] flag_q, flag_d;
  logic [WIDTH-1:0] mark_q, mark_d;
  logic [WIDTH-1:0] hw_clr, sw_clr;
  logic             mark_en;

  always_comb begin
    hw_clr  = ack & (sense_edge | line_high);
    sw_clr  = {WIDTH{sw_wr}} & ~sw_wdata & mark_q;
    flag_d  = set_req | (flag_q & ~(hw_clr | sw_clr));
    mark_en = sw_wr | sw_rd;
    if (sw_wr) mark_d = '0;
    else       mark_d = mark_q | flag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mark_q <= '0;
    else if (mark_en) mark_q <= mark_d;
  end

  assign flags = flag_q;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_chk
      assert_set_only_by_detect_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q[i]) |-> $past(set_req[i]));
      assert_clear_needs_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q[i]) |-> $past(ack[i] || (sw_wr && !sw_wdata[i] && mark_q[i])));
      assert_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        set_req[i] |=> flag_q[i]);
      assert_level_ack_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[i] && !sense_edge[i] && !line_high[i]) |=> flag_q[i]);
    end
  endgenerate
endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
  import irq_flag_pkg::*;
#(
  parameter int unsigned N_LINES = NUM_LINES,
  parameter int unsigned DATA_W  = REG_W,
  parameter int unsigned SYNC_N  = SYNC_LEN
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] irq_n,
  input  logic [N_LINES-1:0] sense_edge,
  input  logic [N_LINES-1:0] ack,
  input  logic               bus_sel,
  input  logic               bus_rd,
  input  logic               bus_wr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  output logic [N_LINES-1:0] pending
);
  localparam int unsigned PAD_W = DATA_W - N_LINES;

  logic [N_LINES-1:0] sync_lvl;
  logic [N_LINES-1:0] set_req;
  logic [N_LINES-1:0] line_high;
  logic [N_LINES-1:0] flags;
  logic               stat_rd, stat_wr, en_we;
  logic [DATA_W-1:0]  en_q, en_d;
  logic [DATA_W-1:0]  status_word;

  irq_sync #(.WIDTH(N_LINES), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(irq_n), .sync_out(sync_lvl)
  );

  irq_detect #(.WIDTH(N_LINES)) u_detect (
    .clk(clk), .rst_n(rst_n), .sync_lvl(sync_lvl), .sense_edge(sense_edge),
    .set_req(set_req), .line_high(line_high)
  );

  irq_flag_bank #(.WIDTH(N_LINES)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_req(set_req), .line_high(line_high),
    .sense_edge(sense_edge), .ack(ack), .sw_rd(stat_rd), .sw_wr(stat_wr),
    .sw_wdata(bus_wdata[N_LINES-1:0]), .flags(flags)
  );

  always_comb begin
    stat_rd     = bus_rd & (bus_sel == SEL_STATUS);
    stat_wr     = bus_wr & (bus_sel == SEL_STATUS);
    en_we       = bus_wr & (bus_sel == SEL_ENABLE);
    en_d        = bus_wdata;
    status_word = {{PAD_W{1'b0}}, flags};
    bus_rdata   = (bus_sel == SEL_ENABLE) ? en_q : status_word;
    pending     = flags & en_q[N_LINES-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     en_q <= '0;
    else if (en_we) en_q <= en_d;
  end

  assert_enable_writeback_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_sel == SEL_ENABLE) |=> (en_q == $past(bus_wdata)));
  assert_enable_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && bus_sel == SEL_ENABLE) |=> $stable(en_q));
  assert_reserved_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel == SEL_STATUS) |-> (bus_rdata[DATA_W-1:N_LINES] == '0));
  assert_pending_needs_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_q[0]) |-> ($past(bus_wr) && $past(bus_sel) == SEL_ENABLE));
endmodule

// File: tb/irq_flag_ctrl_bench.sv
module irq_flag_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] irq_n, sense_edge, ack;
  logic       bus_sel, bus_rd, bus_wr;
  logic [7:0] bus_wdata, bus_rdata;
  logic [5:0] pending;
  logic       pend_probe;

  typedef struct {
    logic [7:0] exp;
    bit         is_pend;
    string      tag;
  } item_t;

  item_t q[$];
  int    n_vec  = 0;
  int    n_fail = 0;
  bit    done   = 1'b0;

  always #5 clk = ~clk;

  irq_flag_ctrl u_irq_flag_ctrl (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .sense_edge(sense_edge), .ack(ack),
    .bus_sel(bus_sel), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pending(pending)
  );

  // Monitor: compares each observation against the next queued expectation.
  always @(negedge clk) begin
    if (bus_rd || pend_probe) begin
      item_t it;
      logic [7:0] act;
      if (q.size() == 0) begin
        n_fail++;
        $display("FAIL monitor: observation with empty queue");
      end else begin
        it  = q.pop_front();
        act = it.is_pend ? {2'b00, pending} : bus_rdata;
        n_vec++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %02h expected %02h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic rd(input logic sel, input logic [7:0] exp, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.exp = exp; it.is_pend = 1'b0; it.tag = tag;
    q.push_back(it);
    bus_sel = sel; bus_rd = 1'b1;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic chk_pend(input logic [5:0] exp, input string tag);
    item_t it;
    @(posedge clk); #1;
    it.exp = {2'b00, exp}; it.is_pend = 1'b1; it.tag = tag;
    q.push_back(it);
    pend_probe = 1'b1;
    @(posedge clk); #1;
    pend_probe = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic [7:0] data);
    @(posedge clk); #1;
    bus_sel = sel; bus_wr = 1'b1; bus_wdata = data;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic pulse_ack(input logic [5:0] lines);
    @(posedge clk); #1;
    ack = lines;
    @(posedge clk); #1;
    ack = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; irq_n = '1; sense_edge = '0; ack = '0;
    bus_sel = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0; pend_probe = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    rd(1'b0, 8'h00, "R1 status reset");
    rd(1'b1, 8'h00, "R1 enable reset");
    chk_pend(6'h00, "R1 pending reset");

    wr(1'b1, 8'hA5);
    rd(1'b1, 8'hA5, "R10 enable readback A5");
    wr(1'b1, 8'h00);
    rd(1'b1, 8'h00, "R10 enable readback 00");

    // R3/R4: writes of 1 do not set anything, reserved bits stay 0.
    wr(1'b0, 8'hFF);
    rd(1'b0, 8'h00, "R4 R3 write ones to status");

    // R6 level latency on line 0.
    irq_n[0] = 1'b0;
    idle(1);
    rd(1'b0, 8'h00, "R6 not yet through synchronizer");
    irq_n[0] = 1'b1; irq_n[0] = 1'b0;
    idle(3);
    rd(1'b0, 8'h01, "R6 level flag set");
    // R9: clear while still low -> set wins.
    wr(1'b0, 8'hFE);
    rd(1'b0, 8'h01, "R9 set wins over software clear");
    irq_n[0] = 1'b1;
    idle(4);
    rd(1'b0, 8'h01, "R6 flag sticky after release");
    wr(1'b0, 8'hFE);
    rd(1'b0, 8'h00, "R5 clear after read of one");

    // R5 write 0 without prior read of 1.
    irq_n[1] = 1'b0;
    idle(4);
    irq_n[1] = 1'b1;
    idle(4);
    wr(1'b0, 8'h00);
    rd(1'b0, 8'h02, "R5 write zero without read ignored");
    wr(1'b0, 8'h00);
    rd(1'b0, 8'h00, "R5 write zero after read clears");

    // R2 read-mark cancelled by an intervening write.
    irq_n[1] = 1'b0;
    idle(4);
    irq_n[1] = 1'b1;
    idle(4);
    rd(1'b0, 8'h02, "R2 status select reads flag");
    wr(1'b0, 8'h02);
    wr(1'b0, 8'h00);
    rd(1'b0, 8'h02, "R5 mark cancelled by earlier write");
    wr(1'b0, 8'h00);
    rd(1'b0, 8'h00, "R5 cleared");

    // R7 edge mode on line 2.
    sense_edge[2] = 1'b1;
    idle(2);
    irq_n[2] = 1'b0;
    idle(4);
    rd(1'b0, 8'h04, "R7 falling edge sets flag");
    wr(1'b0, 8'h00);
    idle(4);
    rd(1'b0, 8'h00, "R7 held low does not set again");
    irq_n[2] = 1'b1;
    idle(4);
    rd(1'b0, 8'h00, "R7 rising edge does not set");
    irq_n[2] = 1'b0;
    idle(4);
    rd(1'b0, 8'h04, "R7 second falling edge sets");
    pulse_ack(6'h04);
    rd(1'b0, 8'h00, "R8 edge ack clears while low");
    irq_n[2] = 1'b1;

    // R8 level ack on line 3.
    irq_n[3] = 1'b0;
    idle(4);
    pulse_ack(6'h08);
    rd(1'b0, 8'h08, "R8 level ack ignored while low");
    irq_n[3] = 1'b1;
    idle(4);
    pulse_ack(6'h08);
    rd(1'b0, 8'h00, "R8 level ack clears when high");

    // R11 pending gating.
    irq_n[3] = 1'b0; irq_n[5] = 1'b0;
    idle(4);
    irq_n[3] = 1'b1; irq_n[5] = 1'b1;
    idle(4);
    chk_pend(6'h00, "R11 pending masked");
    wr(1'b1, 8'hC8);
    chk_pend(6'h08, "R11 pending enabled line 3 only");
    rd(1'b0, 8'h28, "R3 status with reserved zero");
    wr(1'b1, 8'hFF);
    chk_pend(6'h28, "R11 pending both lines");

    idle(3);
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL monitor: %0d expectations left unobserved", q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end
endmodule